// File: doc/BRIEF.md
# Voting Asynchronous Serial Receiver

This block recovers characters from a single serial input line. In oversampled mode the line is sampled on a clock enable that runs at 8, 16 or 32 times the bit rate. Each bit is decided by a majority vote of three samples taken around the middle of the bit. In synchronous mode the same enable acts as a 1x bit clock, and each bit is taken from a single sample. A character is a start bit, 5 to 8 data bits sent least significant bit first, an optional address bit, an optional parity bit, and a stop bit. The start and stop bits are removed. Each finished character is presented for one cycle as data, together with its address bit and four status flags.

The receiver flags framing errors, parity errors, noisy characters and breaks. It also pulses an idle indication once the line has stayed high for one full character time after a character ends. A saturating counter keeps the number of noisy characters received since reset. The configuration inputs are static: change them only while the line is idle.

Top module: `uart_vote_rx`

## Requirements
- R1: `cfg_os_sel` selects the oversampling ratio N: 0 gives 8, 1 gives 16, and 2 or 3 give 32. The tick on which an idle receiver first sees the line low is phase 0 of the start bit. Each bit is sampled at phases N/2-1, N/2 and N/2+1, and the next bit starts N ticks after the current one.
- R2: Each bit takes the majority value of its three samples. The number of data bits is 5 + `cfg_len_sel`. Data bit i is placed at `rx_data[i]`, and all unused upper bits of `rx_data` read 0.
- R3: `rx_noise` is set on a character if the three samples of any of its bits (start, data, address, parity or stop) disagree. `noise_cnt` rises by one in the cycle after such a character is output, and it stays at its all-ones value once it gets there.
- R4: If the start bit votes high, the receiver returns to idle and outputs no character.
- R5: When `cfg_addr_en` is 1, one address bit follows the data bits and is reported on `rx_addr`. When `cfg_addr_en` is 0, `rx_addr` reads 0.
- R6: When `cfg_par_en` is 1, a parity bit follows the address bit, or the data bits if there is no address bit. The expected parity bit depends on `cfg_par_mode`: 0 makes the total count of ones over the data bits, the address bit and the parity bit even; 1 makes that total odd; 2 expects 0; 3 expects 1. `rx_perr` is set when the received parity bit differs from the expected one. When `cfg_par_en` is 0, `rx_perr` reads 0.
- R7: `rx_valid` pulses for one cycle. In oversampled mode the pulse is registered on the tick of the stop bit's third sample. `rx_ferr` is set when the stop bit votes low. A new start bit is accepted from the very next tick, so a stop bit only N/2+2 ticks long is enough.
- R8: `rx_break` (which comes with `rx_ferr` set) is set when every bit of the frame, stop bit included, votes low.
- R9: `rx_idle` pulses once when the line has been high for F·N consecutive ticks after the tick that ended a character (F·1 in synchronous mode). Here F = 2 + the data bit count + the address bit + the parity bit. Any low tick restarts the count. The pulse is not repeated until another character ends.
- R10: With `cfg_sync` = 1, a low line on a tick is taken as the start bit. Each following tick samples one bit directly. `rx_valid` is registered on the stop bit's tick, and `rx_noise` is never set.
- R11: On cycles where `os_tick` is 0, nothing advances, and `rx_valid` and `rx_idle` stay 0 in the following cycle.
- R12: While `rst` is held, and after it is released, `rx_valid`, `rx_idle` and `noise_cnt` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Sample enable (oversample tick, or bit clock in synchronous mode) |
| rxd | input | 1 | Serial line, already synchronised to clk |
| cfg_sync | input | 1 | 1 = synchronous 1x mode |
| cfg_os_sel | input | 2 | Oversampling ratio select |
| cfg_len_sel | input | 2 | Data bits minus 5 |
| cfg_addr_en | input | 1 | Address bit present |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity kind: even, odd, zero, one |
| rx_valid | output | 1 | Character available this cycle |
| rx_data | output | 8 | Received data bits, unused upper bits 0 |
| rx_addr | output | 1 | Received address bit |
| rx_perr | output | 1 | Parity mismatch |
| rx_ferr | output | 1 | Stop bit received low |
| rx_noise | output | 1 | Sample disagreement within the character |
| rx_break | output | 1 | Whole frame received as zeros |
| rx_idle | output | 1 | Idle line pulse |
| noise_cnt | output | NCNT_W | Saturating count of noisy characters |

## Verification
The bench targets several corner cases, and a design that got each wrong would fail as follows.
- A single disturbed sample must leave the bit value intact and still raise the noise flag. A design that sampled only once would corrupt the data or miss the noise.
- Two disturbed samples must flip the bit. A design that voted wrongly would keep the original bit.
- A stop bit cut to N/2+2 ticks, followed at once by a new start, exposes a receiver that waits for the whole stop bit: it drops the second character.
- A low frame checks how breaks and framing errors are told apart from odd parity. A design that confused them would set the wrong flags.
- A line low for only a few ticks exposes a missing start check: such a design outputs a character that was never sent.
- A sample enable with gaps between ticks exposes logic that counts clocks instead of ticks.
- A small counter width brings the noise counter to saturation. A design without saturation would wrap it back to zero.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
    localparam int DATA_MAX  = 8;
    localparam int OS_MAX    = 32;
    localparam int FRAME_MAX = DATA_MAX + 4;
    localparam int PH_W      = $clog2(OS_MAX);
    localparam int RATIO_W   = $clog2(OS_MAX + 1);
    localparam int IDX_W     = $clog2(DATA_MAX);
    localparam int FB_W      = $clog2(FRAME_MAX + 1);
    localparam int CT_W      = $clog2(FRAME_MAX * OS_MAX + 1);

    typedef enum logic [1:0] {
        PAR_EVEN = 2'd0,
        PAR_ODD  = 2'd1,
        PAR_ZERO = 2'd2,
        PAR_ONE  = 2'd3
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_ADDR, ST_PAR, ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic      sync;
        logic [1:0] os_sel;
        logic [1:0] len_sel;
        logic      addr_en;
        logic      par_en;
        par_mode_e par_mode;
    } rx_cfg_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                addr;
        logic                perr;
        logic                ferr;
        logic                noise;
        logic                brk;
    } rx_char_t;

    function automatic logic [RATIO_W-1:0] os_ratio(input logic [1:0] sel);
        case (sel)
            2'd0:    return RATIO_W'(8);
            2'd1:    return RATIO_W'(16);
            default: return RATIO_W'(32);
        endcase
    endfunction

    function automatic logic [FB_W-1:0] frame_bits(input rx_cfg_t c);
        return FB_W'(7) + FB_W'(c.len_sel) + FB_W'(c.addr_en) + FB_W'(c.par_en);
    endfunction

    function automatic logic want_parity(input logic [DATA_MAX-1:0] d, input logic a,
                                         input par_mode_e m);
        case (m)
            PAR_EVEN: return ^{d, a};
            PAR_ODD:  return ~(^{d, a});
            PAR_ZERO: return 1'b0;
            default:  return 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/uvr_vote.sv
module uvr_vote
    import uvr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       rxd,
    input  logic       sync,
    input  logic [1:0] os_sel,
    input  logic       go,
    input  logic       active,
    output logic       strobe,
    output logic       vbit,
    output logic       noisy
);
    logic [RATIO_W-1:0] n;
    logic [PH_W-1:0]    ph, last_ph, m0, m1, m2;
    logic               s0, s1;

    assign n       = os_ratio(os_sel);
    assign last_ph = PH_W'(n - 1'b1);
    assign m1      = PH_W'(n >> 1);
    assign m0      = m1 - 1'b1;
    assign m2      = m1 + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph <= '0;
            s0 <= 1'b0;
            s1 <= 1'b0;
        end else if (tick) begin
            if (go) begin
                ph <= PH_W'(1);
            end else if (active) begin
                ph <= (ph == last_ph) ? '0 : ph + 1'b1;
                if (ph == m0) s0 <= rxd;
                if (ph == m1) s1 <= rxd;
            end
        end
    end

    always_comb begin
        if (sync) begin
            strobe = tick && active;
            vbit   = rxd;
            noisy  = 1'b0;
        end else begin
            strobe = tick && active && (ph == m2);
            vbit   = (s0 & s1) | (s0 & rxd) | (s1 & rxd);
            noisy  = !((s0 == s1) && (s1 == rxd));
        end
    end
endmodule

// File: rtl/uvr_frame.sv
module uvr_frame
    import uvr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxd,
    input  logic      sync,
    input  logic [1:0] len_sel,
    input  logic      addr_en,
    input  logic      par_en,
    input  par_mode_e par_mode,
    input  logic      strobe,
    input  logic      vbit,
    input  logic      noisy,
    output logic      go,
    output logic      active,
    output logic      done,
    output logic      out_valid,
    output rx_char_t  out_char
);
    rx_state_e           st, after_data, after_addr;
    logic [IDX_W-1:0]    idx, last_idx;
    logic [DATA_MAX-1:0] dat;
    logic                adr, pbit, any1, nacc;

    assign go       = tick && (st == ST_IDLE) && !rxd;
    assign active   = (st != ST_IDLE);
    assign done     = strobe && (st == ST_STOP);
    assign last_idx = IDX_W'(4) + IDX_W'(len_sel);

    always_comb begin
        after_addr = par_en ? ST_PAR : ST_STOP;
        after_data = addr_en ? ST_ADDR : after_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            idx       <= '0;
            dat       <= '0;
            adr       <= 1'b0;
            pbit      <= 1'b0;
            any1      <= 1'b0;
            nacc      <= 1'b0;
            out_valid <= 1'b0;
            out_char  <= '0;
        end else begin
            out_valid <= 1'b0;
            if (go) begin
                st   <= sync ? ST_DATA : ST_START;
                idx  <= '0;
                dat  <= '0;
                adr  <= 1'b0;
                pbit <= 1'b0;
                any1 <= 1'b0;
                nacc <= 1'b0;
            end else if (strobe) begin
                nacc <= nacc | noisy;
                unique case (st)
                    ST_START: st <= vbit ? ST_IDLE : ST_DATA;
                    ST_DATA: begin
                        dat[idx] <= vbit;
                        any1     <= any1 | vbit;
                        idx      <= idx + 1'b1;
                        if (idx == last_idx) st <= after_data;
                    end
                    ST_ADDR: begin
                        adr  <= vbit;
                        any1 <= any1 | vbit;
                        st   <= after_addr;
                    end
                    ST_PAR: begin
                        pbit <= vbit;
                        any1 <= any1 | vbit;
                        st   <= ST_STOP;
                    end
                    ST_STOP: begin
                        st             <= ST_IDLE;
                        out_valid      <= 1'b1;
                        out_char.data  <= dat;
                        out_char.addr  <= adr;
                        out_char.perr  <= par_en && (pbit != want_parity(dat, adr, par_mode));
                        out_char.ferr  <= !vbit;
                        out_char.noise <= nacc | noisy;
                        out_char.brk   <= !vbit && !any1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uvr_idle.sv
module uvr_idle
    import uvr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic            rxd,
    input  logic            done,
    input  logic [CT_W-1:0] ct,
    output logic            idle
);
    logic            armed;
    logic [CT_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            run   <= '0;
            idle  <= 1'b0;
        end else begin
            idle <= 1'b0;
            if (tick) begin
                if (done) begin
                    run   <= '0;
                    armed <= 1'b1;
                end else if (!rxd) begin
                    run <= '0;
                end else if (armed) begin
                    if (run + 1'b1 == ct) begin
                        idle  <= 1'b1;
                        armed <= 1'b0;
                        run   <= '0;
                    end else begin
                        run <= run + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
    import uvr_pkg::*;
#(
    parameter int NCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              cfg_sync,
    input  logic [1:0]        cfg_os_sel,
    input  logic [1:0]        cfg_len_sel,
    input  logic              cfg_addr_en,
    input  logic              cfg_par_en,
    input  logic [1:0]        cfg_par_mode,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    output logic              rx_addr,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_noise,
    output logic              rx_break,
    output logic              rx_idle,
    output logic [NCNT_W-1:0] noise_cnt
);
    rx_cfg_t         cfg;
    rx_char_t        ch;
    logic            go, active, done, strobe, vbit, noisy;
    logic [CT_W-1:0] ct;

    assign cfg = '{sync: cfg_sync, os_sel: cfg_os_sel, len_sel: cfg_len_sel,
                   addr_en: cfg_addr_en, par_en: cfg_par_en,
                   par_mode: par_mode_e'(cfg_par_mode)};

    assign ct = cfg.sync ? CT_W'(frame_bits(cfg))
                         : CT_W'(frame_bits(cfg)) * CT_W'(os_ratio(cfg.os_sel));

    uvr_vote u_vote (
        .clk(clk), .rst(rst), .tick(os_tick), .rxd(rxd), .sync(cfg.sync),
        .os_sel(cfg.os_sel), .go(go), .active(active),
        .strobe(strobe), .vbit(vbit), .noisy(noisy)
    );

    uvr_frame u_frame (
        .clk(clk), .rst(rst), .tick(os_tick), .rxd(rxd), .sync(cfg.sync),
        .len_sel(cfg.len_sel), .addr_en(cfg.addr_en), .par_en(cfg.par_en),
        .par_mode(cfg.par_mode), .strobe(strobe), .vbit(vbit), .noisy(noisy),
        .go(go), .active(active), .done(done),
        .out_valid(rx_valid), .out_char(ch)
    );

    uvr_idle u_idle (
        .clk(clk), .rst(rst), .tick(os_tick), .rxd(rxd), .done(done),
        .ct(ct), .idle(rx_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            noise_cnt <= '0;
        end else if (rx_valid && ch.noise && (noise_cnt != {NCNT_W{1'b1}})) begin
            noise_cnt <= noise_cnt + 1'b1;
        end
    end

    assign rx_data  = ch.data;
    assign rx_addr  = ch.addr;
    assign rx_perr  = ch.perr;
    assign rx_ferr  = ch.ferr;
    assign rx_noise = ch.noise;
    assign rx_break = ch.brk;
endmodule

// File: rtl/uvr_checker.sv
module uvr_checker #(
    parameter int NCNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              os_tick,
    input logic              cfg_sync,
    input logic [1:0]        cfg_len_sel,
    input logic              cfg_addr_en,
    input logic              cfg_par_en,
    input logic              rx_valid,
    input logic [7:0]        rx_data,
    input logic              rx_addr,
    input logic              rx_perr,
    input logic              rx_ferr,
    input logic              rx_noise,
    input logic              rx_break,
    input logic              rx_idle,
    input logic [NCNT_W-1:0] noise_cnt
);
    p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_noise_step_r3: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_noise && (noise_cnt != {NCNT_W{1'b1}})
        |=> noise_cnt == NCNT_W'($past(noise_cnt) + 1'b1));

    p_noise_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && rx_noise) |=> $stable(noise_cnt));

    p_tick_gate_r11: assert property (@(posedge clk) disable iff (rst)
        !os_tick |=> !rx_valid && !rx_idle);

    p_break_ferr_r8: assert property (@(posedge clk) disable iff (rst)
        rx_valid && rx_break |-> rx_ferr && (rx_data == 8'h00));

    p_sync_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        rx_valid && cfg_sync |-> !rx_noise);

    p_par_off_r6: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !cfg_par_en |-> !rx_perr);

    p_addr_off_r5: assert property (@(posedge clk) disable iff (rst)
        rx_valid && !cfg_addr_en |-> !rx_addr);

    p_idle_apart_r9: assert property (@(posedge clk) disable iff (rst)
        rx_idle |-> !rx_valid);

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        rx_valid && (cfg_len_sel == 2'd0) |-> rx_data[7:5] == 3'b000);
endmodule

bind uart_vote_rx uvr_checker #(.NCNT_W(NCNT_W)) u_chk (
    .clk(clk), .rst(rst), .os_tick(os_tick), .cfg_sync(cfg_sync),
    .cfg_len_sel(cfg_len_sel), .cfg_addr_en(cfg_addr_en), .cfg_par_en(cfg_par_en),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr(rx_addr), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_noise(rx_noise), .rx_break(rx_break), .rx_idle(rx_idle),
    .noise_cnt(noise_cnt)
);

// File: tb/sim_uart_vote_rx.sv
module sim_uart_vote_rx;
    localparam int CLK_PERIOD = 10;
    localparam int NCNT_W     = 3;
    localparam int CNT_MAX    = (1 << NCNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic os_tick = 1'b0;
    logic rxd = 1'b1;
    logic c_sync = 1'b0;
    logic [1:0] c_os = 2'd0, c_len = 2'd3, c_pm = 2'd0;
    logic c_addr = 1'b0, c_par = 1'b0;
    logic rx_valid, rx_addr, rx_perr, rx_ferr, rx_noise, rx_break, rx_idle;
    logic [7:0] rx_data;
    logic [NCNT_W-1:0] noise_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_vote_rx #(.NCNT_W(NCNT_W)) u0 (
        .clk(clk), .rst(rst), .os_tick(os_tick), .rxd(rxd),
        .cfg_sync(c_sync), .cfg_os_sel(c_os), .cfg_len_sel(c_len),
        .cfg_addr_en(c_addr), .cfg_par_en(c_par), .cfg_par_mode(c_pm),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_addr(rx_addr),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_noise(rx_noise),
        .rx_break(rx_break), .rx_idle(rx_idle), .noise_cnt(noise_cnt)
    );

    typedef struct {
        int d; bit a; bit pe; bit fe; bit nz; bit bk;
    } exp_t;

    exp_t  exp_map[int];
    logic [1:0] line_q[$];
    int    n_tests = 0, n_fail = 0;
    string cur_req = "R12";
    bit    running = 0, finished = 0;
    int    last_id = -1, nxt_id = 0;
    logic [1:0] last_ent = 2'b00;
    int    run_len = 0, model_cnt = 0, rx_seen = 0, idle_seen = 0;
    bit    armed = 0, ev, exp_idle;
    exp_t  e;

    task automatic chk(input int got, input int expv, input string what);
        n_tests++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, expv);
        end
    endtask

    function automatic int ratio();
        return (c_os == 2'd0) ? 8 : (c_os == 2'd1) ? 16 : 32;
    endfunction

    function automatic int ct_now();
        int f = 7 + int'(c_len) + int'(c_addr) + int'(c_par);
        return c_sync ? f : f * ratio();
    endfunction

    function automatic bit par_of(input int d, input bit a);
        int ones = a;
        for (int i = 0; i < 5 + int'(c_len); i++) ones += (d >> i) & 1;
        case (c_pm)
            2'd0: return ones[0];
            2'd1: return !ones[0];
            2'd2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    // reference model and comparison on every clock
    always @(negedge clk) begin
        if (running) begin
            ev = (last_id >= 0) && exp_map.exists(last_id);
            if (ev) e = exp_map[last_id];
            exp_idle = 1'b0;
            if (last_ent[1]) begin
                if (ev) begin run_len = 0; armed = 1; end
                else if (!last_ent[0]) run_len = 0;
                else if (armed) begin
                    run_len++;
                    if (run_len == ct_now()) begin exp_idle = 1; armed = 0; run_len = 0; end
                end
            end
            chk(int'(rx_valid), int'(ev), "valid");
            if (rx_valid) rx_seen++;
            if (ev) begin
                chk(int'(rx_data), e.d, "data");
                chk(int'(rx_addr), int'(e.a), "addr R5");
                chk(int'(rx_perr), int'(e.pe), "perr R6");
                chk(int'(rx_ferr), int'(e.fe), "ferr R7");
                chk(int'(rx_noise), int'(e.nz), "noise R3");
                chk(int'(rx_break), int'(e.bk), "break R8");
            end
            chk(int'(rx_idle), int'(exp_idle), "idle R9");
            if (rx_idle) idle_seen++;
            chk(int'(noise_cnt), model_cnt, "noise count R3");
            if (ev && e.nz && model_cnt != CNT_MAX) model_cnt++;
            if (line_q.size() > 0) last_ent = line_q.pop_front();
            else last_ent = 2'b11;
            os_tick = last_ent[1];
            rxd     = last_ent[0];
            last_id = nxt_id;
            nxt_id++;
        end
    end

    task automatic push(input bit t, input bit v);
        line_q.push_back({t, v});
    endtask

    task automatic pad(input int n);
        for (int i = 0; i < n; i++) push(1'b1, 1'b1);
    endtask

    // gt: 1 flips the middle sample, 2 flips the first two samples
    task automatic send(input int d, input bit a = 0, input bit pflip = 0, input bit stop_v = 1,
                        input int gb = -1, input int gt = 0, input int stop_ticks = 0,
                        input bit gap = 0);
        bit bits[$];
        bit vot[$];
        int n = ratio(), mid = ratio() / 2, nb, ev_id = 0, k, dv = 0, tk;
        exp_t x;
        bits.push_back(1'b0);
        for (int i = 0; i < 5 + int'(c_len); i++) bits.push_back(bit'((d >> i) & 1));
        if (c_addr) bits.push_back(a);
        if (c_par) bits.push_back(par_of(d, a) ^ pflip);
        bits.push_back(stop_v);
        nb = bits.size();
        for (int b = 0; b < nb; b++) begin
            vot.push_back((!c_sync && b == gb && gt == 2) ? ~bits[b] : bits[b]);
            tk = c_sync ? 1 : ((b == nb - 1 && stop_ticks > 0) ? stop_ticks : n);
            for (int ph = 0; ph < tk; ph++) begin
                bit s = bits[b];
                if (!c_sync && b == gb) begin
                    if (gt == 1 && ph == mid) s = ~s;
                    if (gt == 2 && (ph == mid - 1 || ph == mid)) s = ~s;
                end
                if (b == nb - 1 && (c_sync || ph == mid + 1)) ev_id = nxt_id + line_q.size();
                push(1'b1, s);
                if (gap) push(1'b0, s);
            end
        end
        k = 1;
        for (int i = 0; i < 5 + int'(c_len); i++) begin
            dv |= int'(vot[k]) << i;
            k++;
        end
        x.d = dv;
        x.a = c_addr ? vot[k] : 1'b0;
        if (c_addr) k++;
        x.pe = c_par ? (vot[k] != par_of(dv, x.a)) : 1'b0;
        x.fe = !vot[nb - 1];
        x.nz = !c_sync && (gb >= 0);
        x.bk = 1'b1;
        for (int b = 1; b < nb; b++) if (vot[b]) x.bk = 1'b0;
        exp_map[ev_id] = x;
    endtask

    task automatic set_cfg(input bit s, input int os, input int ln, input bit a, input bit p,
                           input int pm);
        c_sync = s; c_os = 2'(os); c_len = 2'(ln); c_addr = a; c_par = p; c_pm = 2'(pm);
    endtask

    task automatic drain();
        pad(420);
        while (line_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int s0, i0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        cur_req = "R12";
        chk(int'(rx_valid), 0, "valid in reset");
        chk(int'(noise_cnt), 0, "count in reset");
        rst = 1'b0;
        @(negedge clk);
        chk(int'(rx_valid), 0, "valid after reset");
        chk(int'(rx_idle), 0, "idle after reset");
        chk(int'(noise_cnt), 0, "count after reset");
        running = 1;

        cur_req = "R2";
        set_cfg(0, 0, 3, 0, 0, 0);
        @(posedge clk);
        send(8'hA5); send(8'h3C); send(8'hFF); send(8'h00); send(8'h69);
        drain();

        cur_req = "R1";
        set_cfg(0, 1, 0, 0, 0, 0);
        @(posedge clk); send(8'h15); send(8'h0A); drain();
        set_cfg(0, 2, 1, 0, 0, 0);
        @(posedge clk); send(8'h2B); send(8'h14); drain();
        set_cfg(0, 3, 2, 0, 0, 0);
        @(posedge clk); send(8'h55); drain();

        cur_req = "R3";
        set_cfg(0, 1, 3, 0, 0, 0);
        @(posedge clk);
        send(8'h5A, 0, 0, 1, 3, 1);
        send(8'h5A, 0, 0, 1, 9, 1);
        send(8'hC1, 0, 0, 1, 0, 1);
        send(8'h0F, 0, 0, 1, 5, 2);
        drain();
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); send(i * 17 + 3, 0, 0, 1, 2, 1);
        end
        drain();
        chk(int'(noise_cnt), CNT_MAX, "saturated count R3");

        cur_req = "R4";
        s0 = rx_seen;
        @(posedge clk);
        push(1, 0); push(1, 0); push(1, 0); pad(40);
        send(8'h77);
        drain();
        chk(rx_seen - s0, 1, "only the real character R4");

        cur_req = "R5";
        set_cfg(0, 0, 3, 1, 0, 0);
        @(posedge clk); send(8'h81, 1); send(8'h7E, 0); send(8'h00, 1); drain();

        cur_req = "R6";
        for (int pm = 0; pm < 4; pm++) begin
            set_cfg(0, 0, 3, 1, 1, pm);
            @(posedge clk);
            send(8'h6B, 1); send(8'h6B, 1, 1); send(8'h12, 0); send(8'h12, 0, 1);
            drain();
        end

        cur_req = "R7";
        set_cfg(0, 0, 3, 0, 0, 0);
        @(posedge clk);
        send(8'h3D, 0, 0, 0, -1, 0, 6);
        pad(20);
        send(8'hC6, 0, 0, 1, -1, 0, 6);
        send(8'h9E, 0, 0, 1, -1, 0, 6);
        send(8'h01);
        drain();

        cur_req = "R8";
        set_cfg(0, 0, 3, 1, 1, 0);
        @(posedge clk); send(8'h00, 0, 0, 0, -1, 0, 6); drain();
        set_cfg(0, 0, 3, 1, 1, 1);
        @(posedge clk); send(8'h00, 0, 0, 0, -1, 0, 6); drain();

        cur_req = "R9";
        set_cfg(0, 0, 3, 0, 0, 0);
        i0 = idle_seen;
        @(posedge clk); send(8'h44); drain();
        chk(idle_seen - i0, 1, "one idle pulse R9");

        cur_req = "R10";
        set_cfg(1, 0, 3, 1, 1, 1);
        @(posedge clk);
        send(8'hC3, 1); send(8'h12, 0); send(8'h5E, 1, 1); send(8'hA0, 0, 0, 0);
        drain();
        set_cfg(1, 0, 0, 0, 0, 0);
        @(posedge clk); send(8'h1B); send(8'h04); drain();

        cur_req = "R11";
        set_cfg(0, 0, 3, 0, 0, 0);
        @(posedge clk);
        send(8'h96, 0, 0, 1, -1, 0, 0, 1);
        send(8'h21, 0, 0, 1, -1, 0, 0, 1);
        drain();

        cur_req = "R2";
        chk(rx_seen, exp_map.size(), "total characters");
        running = 0;
        summary();
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL %s watchdog: got timeout expected completion", cur_req);
        summary();
    end
endmodule